// File: doc/BRIEF.md
# Split Read Completion Tracker

This block tracks outstanding non-posted memory reads and checks each returning completion header against them. When a read goes out, the request side claims a table slot by its tag and stores the total number of bytes the read asked for. The completion side receives the three-doubleword completion header as three 32-bit words under a valid/ready handshake. It decodes the fields and looks up the table entry. A completion that passes all checks moves the remaining count down by the bytes it carries, and the tag is released once nothing is left to receive.

A read can be answered by several completions. Each one states how many bytes were still outstanding when it was sent, including its own bytes. The tracker compares that figure with its own count, works out how many bytes the completion carries from the payload length and the starting byte offset, and reports a result word with the tag, a last flag, the offset and the status. Headers that cannot be accepted produce one of four error pulses and leave the table untouched. Payload data, flow-control credits and digest checking are handled elsewhere.

Top module: `split_cpl_tracker`

## Requirements
- R1: Header words are accepted when `cpl_valid` and `cpl_ready` are both high. Words arrive in order DW0, DW1, DW2. `cpl_ready` is low for exactly the one cycle after DW2 is accepted. The single result or error pulse is high in the cycle after that, which is two clock edges after the edge that accepts DW2.
- R2: Field positions are as follows. DW0 has format [31:29], type [28:24], tag bit 9 at [23], tag bit 8 at [19] and length [9:0]. DW1 has status [15:13] and byte count [11:0]. DW2 has requester ID [31:16], tag bits 7..0 at [15:8] and lower address [6:0]. A header is malformed if its type is not 01010b, if its format is neither 000b (no data) nor 010b (with data), or if it reports successful status with format 000b. A malformed header raises `err_malformed`.
- R3: Status 000b (successful), 001b (unsupported request), 010b (configuration retry) and 100b (completer abort) are accepted. Any other status value raises `err_malformed`.
- R4: The 10-bit tag is {DW0[23], DW0[19], DW2[15:8]} and is reported on `res_tag`. A tag of value NUM_ENTRIES (32) or more is never outstanding.
- R5: An allocation stores the requested byte count as the remaining count. `alloc_busy` is high in the same cycle, and the allocation is refused, if the tag is already in use, is out of range, or if the byte count is zero.
- R6: A length field of 0 stands for 1024 doublewords. Available bytes are length×4 minus the byte offset. `res_bytes` is the smaller of the available bytes and the byte count.
- R7: A successful completion is last when its byte count does not exceed the available bytes. A last completion frees the tag. Otherwise the remaining count becomes the byte count minus `res_bytes`.
- R8: `res_offset` is lower address bits [1:0]. Lower address bits [6:2] have no effect on any output.
- R9: A completion for a tag that is not in use raises `err_unknown_tag` and changes no table entry.
- R10: A successful completion whose byte count differs from the stored remaining count raises `err_count` and changes no table entry.
- R11: A requester ID that differs from `local_id` raises `err_requester` and changes no table entry.
- R12: A valid non-successful status ends the request at once. It is reported with `res_last`=1, `res_bytes`=0 and the status code, the tag is freed, and no byte-count check is made.
- R13: A completion may free one tag on the same edge at which an allocation claims a different tag. An allocation of the tag that is being freed on that same edge is refused as busy.
- R14: Each header produces exactly one pulse, either `res_valid` or one of the errors. Errors are ranked malformed, then requester, then unknown tag, then count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_id | input | 16 | Requester ID expected in completions |
| alloc_valid | input | 1 | Allocation request |
| alloc_tag | input | 5 | Table slot (tag) to claim |
| alloc_bytes | input | 12 | Total bytes requested by the read |
| alloc_busy | output | 1 | Allocation refused (combinational) |
| cpl_valid | input | 1 | Header word valid |
| cpl_word | input | 32 | Header word |
| cpl_ready | output | 1 | Header word accepted |
| res_valid | output | 1 | Accepted completion result pulse |
| res_tag | output | 10 | Full tag of the completion |
| res_last | output | 1 | Request finished by this completion |
| res_offset | output | 2 | Starting byte offset in first data doubleword |
| res_status | output | 3 | Completion status code |
| res_bytes | output | 12 | Bytes carried by this completion |
| err_malformed | output | 1 | Bad type, format or status |
| err_requester | output | 1 | Requester ID mismatch |
| err_unknown_tag | output | 1 | Tag not outstanding |
| err_count | output | 1 | Byte count differs from remaining count |

## Verification
Several properties are checked on every cycle. Each header gives exactly one pulse, and that pulse comes one cycle after the header is complete. An allocation never lands on an occupied slot or on the slot being freed. An accepted successful completion always matches the stored count. A partial completion always leaves a nonzero remainder. Only the bench scenarios can show the split arithmetic over every offset and several lengths, the 1024-doubleword encoding, the ranking of errors, and that rejected headers leave the table as it was, which is seen through later completions and allocations.

// File: rtl/cpltrk_pkg.sv
package cpltrk_pkg;

    localparam int WORD_W = 32;
    localparam int TAG_W  = 10;
    localparam int BC_W   = 12;
    localparam int LEN_W  = 10;
    localparam int ID_W   = 16;
    localparam int LA_W   = 7;
    localparam int AVL_W  = BC_W + 1;

    localparam logic [4:0] TYPE_CPL     = 5'b01010;
    localparam logic [2:0] FMT_NODATA   = 3'b000;
    localparam logic [2:0] FMT_DATA     = 3'b010;

    localparam logic [2:0] ST_OK        = 3'b000;
    localparam logic [2:0] ST_UNSUP     = 3'b001;
    localparam logic [2:0] ST_RETRY     = 3'b010;
    localparam logic [2:0] ST_ABORT     = 3'b100;

    typedef struct packed {
        logic [2:0]       fmt;
        logic [4:0]       typ;
        logic [TAG_W-1:0] tag;
        logic [ID_W-1:0]  rid;
        logic [2:0]       status;
        logic [BC_W-1:0]  bc;
        logic [LEN_W-1:0] len;
        logic [LA_W-1:0]  laddr;
    } cpl_hdr_t;

    typedef enum logic [2:0] {
        OUT_OK,
        OUT_MALFORMED,
        OUT_REQUESTER,
        OUT_UNKNOWN,
        OUT_COUNT
    } outcome_e;

    typedef struct packed {
        outcome_e         kind;
        logic             last;
        logic [1:0]       offset;
        logic [2:0]       status;
        logic [BC_W-1:0]  bytes;
        logic [BC_W-1:0]  new_rem;
    } cpl_eval_t;

    function automatic logic status_known(input logic [2:0] st);
        return (st == ST_OK) || (st == ST_UNSUP) || (st == ST_RETRY) || (st == ST_ABORT);
    endfunction

    // Payload bytes of a length field; zero encodes the largest payload.
    function automatic logic [AVL_W-1:0] payload_bytes(input logic [LEN_W-1:0] len);
        logic [AVL_W-1:0] dws;
        dws = (len == '0) ? AVL_W'(1 << LEN_W) : AVL_W'(len);
        return dws << 2;
    endfunction

    function automatic cpl_hdr_t unpack_hdr(input logic [WORD_W-1:0] w0,
                                            input logic [WORD_W-1:0] w1,
                                            input logic [WORD_W-1:0] w2);
        cpl_hdr_t h;
        h.fmt    = w0[31:29];
        h.typ    = w0[28:24];
        h.tag    = {w0[23], w0[19], w2[15:8]};
        h.len    = w0[LEN_W-1:0];
        h.status = w1[15:13];
        h.bc     = w1[BC_W-1:0];
        h.rid    = w2[31:16];
        h.laddr  = w2[LA_W-1:0];
        return h;
    endfunction

endpackage

// File: rtl/cpltrk_hdr_rx.sv
module cpltrk_hdr_rx
    import cpltrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              hdr_valid,
    output cpl_hdr_t          hdr
);

    localparam int NWORDS = 3;
    localparam int CNT_W  = $clog2(NWORDS);

    logic [CNT_W-1:0]  word_cnt;
    logic [WORD_W-1:0] w0_q;
    logic [WORD_W-1:0] w1_q;
    logic              take;

    assign in_ready = !hdr_valid;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_cnt  <= '0;
            w0_q      <= '0;
            w1_q      <= '0;
            hdr_valid <= 1'b0;
            hdr       <= '0;
        end else begin
            hdr_valid <= 1'b0;
            if (take) begin
                if (word_cnt == CNT_W'(NWORDS - 1)) begin
                    hdr       <= unpack_hdr(w0_q, w1_q, in_word);
                    hdr_valid <= 1'b1;
                    word_cnt  <= '0;
                end else begin
                    if (word_cnt == '0) w0_q <= in_word;
                    else                w1_q <= in_word;
                    word_cnt <= word_cnt + 1'b1;
                end
            end
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (take && word_cnt == CNT_W'(NWORDS - 1)) |=> !in_ready); // R1

    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready); // R1

endmodule

// File: rtl/cpltrk_table.sv
module cpltrk_table
    import cpltrk_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_we,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic [BC_W-1:0]        alloc_bytes,
    input  logic                   upd_we,
    input  logic                   upd_free,
    input  logic [IDX_W-1:0]       upd_idx,
    input  logic [BC_W-1:0]        upd_rem,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic                   rd_inuse,
    output logic [BC_W-1:0]        rd_rem,
    output logic [NUM_ENTRIES-1:0] inuse_vec
);

    logic [BC_W-1:0] rem_q [NUM_ENTRIES];

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        logic hit_alloc;
        logic hit_upd;
        assign hit_alloc = alloc_we && (alloc_idx == IDX_W'(i));
        assign hit_upd   = upd_we   && (upd_idx   == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                inuse_vec[i] <= 1'b0;
                rem_q[i]     <= '0;
            end else if (hit_alloc) begin
                inuse_vec[i] <= 1'b1;
                rem_q[i]     <= alloc_bytes;
            end else if (hit_upd) begin
                if (upd_free) begin
                    inuse_vec[i] <= 1'b0;
                    rem_q[i]     <= '0;
                end else begin
                    rem_q[i]     <= upd_rem;
                end
            end
        end

        AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (hit_upd && upd_free) |=> !inuse_vec[i]); // R7
    end

    assign rd_inuse = (32'(rd_idx) < NUM_ENTRIES) ? inuse_vec[rd_idx] : 1'b0;
    assign rd_rem   = (32'(rd_idx) < NUM_ENTRIES) ? rem_q[rd_idx]     : '0;

    AST_ALLOC_EMPTY_SLOT: assert property (@(posedge clk) disable iff (rst)
        alloc_we |-> !inuse_vec[alloc_idx]); // R5

    AST_NO_SHARED_SLOT: assert property (@(posedge clk) disable iff (rst)
        (alloc_we && upd_we) |-> (alloc_idx != upd_idx)); // R13

    AST_INUSE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rd_inuse |-> (rd_rem != '0)); // R7

endmodule

// File: rtl/cpltrk_eval.sv
module cpltrk_eval
    import cpltrk_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
)(
    input  cpl_hdr_t         hdr,
    input  logic [ID_W-1:0]  local_id,
    input  logic             ent_inuse,
    input  logic [BC_W-1:0]  ent_rem,
    output logic [IDX_W-1:0] idx,
    output cpl_eval_t        ev
);

    logic             bad_shape;
    logic             in_range;
    logic             is_ok;
    logic [1:0]       offset;
    logic [AVL_W-1:0] avail;
    logic             fits;

    assign idx      = hdr.tag[IDX_W-1:0];
    assign in_range = 32'(hdr.tag) < NUM_ENTRIES;
    assign is_ok    = (hdr.status == ST_OK);
    assign offset   = hdr.laddr[1:0];

    assign bad_shape = (hdr.typ != TYPE_CPL)
                    || !((hdr.fmt == FMT_NODATA) || (hdr.fmt == FMT_DATA))
                    || !status_known(hdr.status)
                    || (is_ok && hdr.fmt != FMT_DATA);

    assign avail = payload_bytes(hdr.len) - AVL_W'(offset);
    assign fits  = {1'b0, hdr.bc} <= avail;

    always_comb begin
        ev        = '0;
        ev.offset = offset;
        ev.status = hdr.status;
        if (bad_shape) begin
            ev.kind = OUT_MALFORMED;
        end else if (hdr.rid != local_id) begin
            ev.kind = OUT_REQUESTER;
        end else if (!in_range || !ent_inuse) begin
            ev.kind = OUT_UNKNOWN;
        end else if (is_ok && hdr.bc != ent_rem) begin
            ev.kind = OUT_COUNT;
        end else begin
            ev.kind = OUT_OK;
        end

        if (!is_ok) begin
            ev.last    = 1'b1;
            ev.bytes   = '0;
            ev.new_rem = '0;
        end else if (fits) begin
            ev.last    = 1'b1;
            ev.bytes   = hdr.bc;
            ev.new_rem = '0;
        end else begin
            ev.last    = 1'b0;
            ev.bytes   = avail[BC_W-1:0];
            ev.new_rem = hdr.bc - avail[BC_W-1:0];
        end
    end

endmodule

// File: rtl/split_cpl_tracker.sv
module split_cpl_tracker
    import cpltrk_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       local_id,
    input  logic              alloc_valid,
    input  logic [IDX_W-1:0]  alloc_tag,
    input  logic [11:0]       alloc_bytes,
    output logic              alloc_busy,
    input  logic              cpl_valid,
    input  logic [31:0]       cpl_word,
    output logic              cpl_ready,
    output logic              res_valid,
    output logic [9:0]        res_tag,
    output logic              res_last,
    output logic [1:0]        res_offset,
    output logic [2:0]        res_status,
    output logic [11:0]       res_bytes,
    output logic              err_malformed,
    output logic              err_requester,
    output logic              err_unknown_tag,
    output logic              err_count
);

    logic                   hdr_valid;
    cpl_hdr_t               hdr;
    logic [IDX_W-1:0]       ent_idx;
    logic                   ent_inuse;
    logic [BC_W-1:0]        ent_rem;
    logic [NUM_ENTRIES-1:0] inuse_vec;
    cpl_eval_t              ev;
    logic                   alloc_slot_taken;
    logic                   alloc_we;
    logic                   upd_we;

    cpltrk_hdr_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (cpl_valid),
        .in_word   (cpl_word),
        .in_ready  (cpl_ready),
        .hdr_valid (hdr_valid),
        .hdr       (hdr)
    );

    cpltrk_eval #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_eval (
        .hdr       (hdr),
        .local_id  (local_id),
        .ent_inuse (ent_inuse),
        .ent_rem   (ent_rem),
        .idx       (ent_idx),
        .ev        (ev)
    );

    assign upd_we = hdr_valid && (ev.kind == OUT_OK);

    always_comb begin
        alloc_slot_taken = 1'b1;
        if (32'(alloc_tag) < NUM_ENTRIES) alloc_slot_taken = inuse_vec[alloc_tag];
    end

    assign alloc_busy = alloc_valid && (alloc_slot_taken || alloc_bytes == '0);
    assign alloc_we   = alloc_valid && !alloc_busy;

    cpltrk_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk         (clk),
        .rst         (rst),
        .alloc_we    (alloc_we),
        .alloc_idx   (alloc_tag),
        .alloc_bytes (alloc_bytes),
        .upd_we      (upd_we),
        .upd_free    (ev.last),
        .upd_idx     (ent_idx),
        .upd_rem     (ev.new_rem),
        .rd_idx      (ent_idx),
        .rd_inuse    (ent_inuse),
        .rd_rem      (ent_rem),
        .inuse_vec   (inuse_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid       <= 1'b0;
            res_tag         <= '0;
            res_last        <= 1'b0;
            res_offset      <= '0;
            res_status      <= '0;
            res_bytes       <= '0;
            err_malformed   <= 1'b0;
            err_requester   <= 1'b0;
            err_unknown_tag <= 1'b0;
            err_count       <= 1'b0;
        end else begin
            res_valid       <= hdr_valid && (ev.kind == OUT_OK);
            err_malformed   <= hdr_valid && (ev.kind == OUT_MALFORMED);
            err_requester   <= hdr_valid && (ev.kind == OUT_REQUESTER);
            err_unknown_tag <= hdr_valid && (ev.kind == OUT_UNKNOWN);
            err_count       <= hdr_valid && (ev.kind == OUT_COUNT);
            if (hdr_valid) begin
                res_tag    <= hdr.tag;
                res_last   <= ev.last;
                res_offset <= ev.offset;
                res_status <= ev.status;
                res_bytes  <= ev.bytes;
            end
        end
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, err_malformed, err_requester, err_unknown_tag, err_count})); // R14

    AST_PULSE_PER_HEADER: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> ($countones({res_valid, err_malformed, err_requester,
                                   err_unknown_tag, err_count}) == 1)); // R1

    AST_COUNT_AGREES: assert property (@(posedge clk) disable iff (rst)
        (upd_we && hdr.status == ST_OK) |-> (hdr.bc == ent_rem)); // R10

    AST_PARTIAL_LEAVES_REST: assert property (@(posedge clk) disable iff (rst)
        (upd_we && !ev.last) |-> (ev.new_rem != '0 && ev.bytes != '0)); // R7

    AST_UPDATE_ONLY_LIVE: assert property (@(posedge clk) disable iff (rst)
        upd_we |-> ent_inuse); // R9

endmodule

// File: tb/split_cpl_tracker_tb_top.sv
module split_cpl_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NENT       = 32;
    localparam logic [15:0] MY_ID = 16'h0A10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 1'b0;
    logic [4:0]  alloc_tag = '0;
    logic [11:0] alloc_bytes = '0;
    logic        alloc_busy;
    logic        cpl_valid = 1'b0;
    logic [31:0] cpl_word = '0;
    logic        cpl_ready;
    logic        res_valid;
    logic [9:0]  res_tag;
    logic        res_last;
    logic [1:0]  res_offset;
    logic [2:0]  res_status;
    logic [11:0] res_bytes;
    logic        err_malformed, err_requester, err_unknown_tag, err_count;

    int checks = 0;
    int errors = 0;

    bit m_use [NENT];
    int m_rem [NENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    split_cpl_tracker dut_i (
        .clk(clk), .rst(rst), .local_id(MY_ID),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_bytes(alloc_bytes),
        .alloc_busy(alloc_busy),
        .cpl_valid(cpl_valid), .cpl_word(cpl_word), .cpl_ready(cpl_ready),
        .res_valid(res_valid), .res_tag(res_tag), .res_last(res_last),
        .res_offset(res_offset), .res_status(res_status), .res_bytes(res_bytes),
        .err_malformed(err_malformed), .err_requester(err_requester),
        .err_unknown_tag(err_unknown_tag), .err_count(err_count)
    );

    task automatic chk(input int act, input int exp, input string rq, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Starts and ends just after a falling edge.
    task automatic do_alloc(input int tag, input int bytes, input string rq);
        bit exp_busy;
        alloc_valid = 1'b1;
        alloc_tag   = 5'(tag);
        alloc_bytes = 12'(bytes);
        exp_busy = (tag >= NENT) || m_use[tag] || (bytes == 0);
        #1;
        chk(int'(alloc_busy), int'(exp_busy), rq, "alloc_busy");
        @(posedge clk);
        if (!exp_busy) begin m_use[tag] = 1'b1; m_rem[tag] = bytes; end
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_cpl(input logic [2:0] fmt, input logic [4:0] typ, input int tag,
                          input logic [15:0] rid, input logic [2:0] st, input int bc,
                          input int len, input int la, input string rq,
                          input bit side_en, input int side_tag, input int side_bytes);
        logic [9:0] t;
        bit mal, ok, last, side_busy;
        int avail, bytes, kind;
        t = 10'(tag);
        cpl_valid = 1'b1;
        cpl_word  = {fmt, typ, t[9], 3'b000, t[8], 5'b00000, 2'b00, 2'b00, 10'(len)};
        @(posedge clk); @(negedge clk);
        cpl_word  = {16'h7E31, st, 1'b0, 12'(bc)};
        @(posedge clk); @(negedge clk);
        cpl_word  = {rid, t[7:0], 1'b0, 7'(la)};
        @(posedge clk); @(negedge clk);
        cpl_valid = 1'b0;
        chk(int'(cpl_ready), 0, "R1", "ready after third word");
        chk(int'(res_valid | err_malformed | err_requester | err_unknown_tag | err_count),
            0, "R1", "no pulse before evaluation");
        side_busy = 1'b0;
        if (side_en) begin
            alloc_valid = 1'b1;
            alloc_tag   = 5'(side_tag);
            alloc_bytes = 12'(side_bytes);
            side_busy = m_use[side_tag] || (side_bytes == 0);
            #1;
            chk(int'(alloc_busy), int'(side_busy), "R13", "same-edge alloc busy");
        end
        @(posedge clk);
        if (side_en && !side_busy) begin m_use[side_tag] = 1'b1; m_rem[side_tag] = side_bytes; end
        @(negedge clk);
        alloc_valid = 1'b0;

        mal = (typ != 5'b01010) || !(fmt == 3'b000 || fmt == 3'b010) ||
              !(st == 0 || st == 1 || st == 2 || st == 4) || (st == 0 && fmt != 3'b010);
        if (mal)                                kind = 1;
        else if (rid != MY_ID)                  kind = 2;
        else if (tag >= NENT || !m_use[tag])    kind = 3;
        else if (st == 0 && bc != m_rem[tag])   kind = 4;
        else                                    kind = 0;
        ok = (kind == 0);
        avail = ((len == 0) ? 1024 : len) * 4 - (la % 4);
        if (st != 0) begin last = 1'b1; bytes = 0; end
        else if (bc <= avail) begin last = 1'b1; bytes = bc; end
        else begin last = 1'b0; bytes = avail; end

        chk(int'(res_valid),       int'(kind == 0), rq, "res_valid");
        chk(int'(err_malformed),   int'(kind == 1), rq, "err_malformed");
        chk(int'(err_requester),   int'(kind == 2), rq, "err_requester");
        chk(int'(err_unknown_tag), int'(kind == 3), rq, "err_unknown_tag");
        chk(int'(err_count),       int'(kind == 4), rq, "err_count");
        if (ok) begin
            chk(int'(res_tag),    tag,        rq, "res_tag");
            chk(int'(res_last),   int'(last), rq, "res_last");
            chk(int'(res_offset), la % 4,     rq, "res_offset");
            chk(int'(res_status), int'(st),   rq, "res_status");
            chk(int'(res_bytes),  bytes,      rq, "res_bytes");
            if (last) m_use[tag] = 1'b0;
            else      m_rem[tag] = bc - bytes;
        end
    endtask

    task automatic good_cpl(input int tag, input int bc, input int len, input int la, input string rq);
        do_cpl(3'b010, 5'b01010, tag, MY_ID, 3'b000, bc, len, la, rq, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NENT; i++) begin m_use[i] = 1'b0; m_rem[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(int'(cpl_ready), 1, "R1", "reset ready");
        chk(int'(res_valid | err_malformed | err_requester | err_unknown_tag | err_count),
            0, "R14", "reset pulses");

        // R5 allocation refusal
        do_alloc(3, 0,   "R5");
        do_alloc(3, 100, "R5");
        do_alloc(3, 7,   "R5");
        good_cpl(3, 100, 32, 0, "R7");

        // R6 R7 R8 sweep over offset and length, with split completions
        for (int off = 0; off < 4; off++) begin
            for (int li = 0; li < 4; li++) begin
                int len, tag, guard;
                bit first;
                len = (li == 3) ? 16 : li + 1;
                tag = off * 4 + li;
                do_alloc(tag, 37 + 13 * li + off, "R5");
                first = 1'b1;
                guard = 0;
                while (m_use[tag] && guard < 40) begin
                    good_cpl(tag, m_rem[tag], len, first ? (off + 8 * li) : 4 * li, "R8");
                    first = 1'b0;
                    guard++;
                end
                chk(int'(m_use[tag]), 0, "R7", "sweep finished");
            end
        end

        // R6 zero length stands for 1024 doublewords
        do_alloc(20, 4095, "R6");
        good_cpl(20, 4095, 0, 1, "R6");
        do_alloc(20, 4095, "R6");
        good_cpl(20, 4095, 512, 0, "R6");
        good_cpl(20, 2047, 0, 0, "R6");

        // R4 R9 unknown tags, extended bits
        do_alloc(5, 64, "R9");
        good_cpl(6, 64, 16, 0, "R9");
        good_cpl(256 + 5, 64, 16, 0, "R4");
        good_cpl(512 + 5, 64, 16, 0, "R4");
        good_cpl(40, 64, 16, 0, "R4");

        // R11 requester mismatch, R10 count mismatch, table unchanged
        do_cpl(3'b010, 5'b01010, 5, 16'h0A11, 3'b000, 64, 16, 0, "R11", 1'b0, 0, 0);
        good_cpl(5, 60, 16, 0, "R10");
        good_cpl(5, 64, 4, 0, "R10");
        good_cpl(5, 48, 16, 0, "R9");
        do_alloc(5, 9, "R9");

        // R2 R3 malformed headers
        do_alloc(7, 32, "R2");
        do_cpl(3'b010, 5'b01011, 7, MY_ID, 3'b000, 32, 8, 0, "R2", 1'b0, 0, 0);
        do_cpl(3'b001, 5'b01010, 7, MY_ID, 3'b000, 32, 8, 0, "R2", 1'b0, 0, 0);
        do_cpl(3'b000, 5'b01010, 7, MY_ID, 3'b000, 32, 8, 0, "R2", 1'b0, 0, 0);
        for (int s = 0; s < 8; s++)
            if (s != 0) do_cpl(3'b000, 5'b01010, 40, MY_ID, 3'(s), 0, 0, 0, "R3", 1'b0, 0, 0);
        // R14 ranking: malformed before requester, requester before unknown
        do_cpl(3'b011, 5'b01010, 40, 16'h1111, 3'b000, 32, 8, 0, "R14", 1'b0, 0, 0);
        do_cpl(3'b010, 5'b01010, 40, 16'h1111, 3'b000, 32, 8, 0, "R14", 1'b0, 0, 0);
        good_cpl(7, 32, 8, 0, "R2");

        // R12 error status ends the request
        do_alloc(8, 300, "R12");
        good_cpl(8, 300, 16, 0, "R12");
        do_cpl(3'b000, 5'b01010, 8, MY_ID, 3'b001, 5, 0, 2, "R12", 1'b0, 0, 0);
        do_alloc(8, 12, "R12");
        do_cpl(3'b010, 5'b01010, 8, MY_ID, 3'b100, 0, 1, 0, "R12", 1'b0, 0, 0);
        do_alloc(8, 12, "R12");
        do_cpl(3'b000, 5'b01010, 8, MY_ID, 3'b010, 0, 0, 0, "R12", 1'b0, 0, 0);

        // R13 same-edge free and allocate
        do_alloc(9, 16, "R13");
        do_cpl(3'b010, 5'b01010, 9, MY_ID, 3'b000, 16, 4, 0, "R13", 1'b1, 10, 40);
        do_alloc(9, 8,  "R13");
        do_alloc(10, 8, "R13");
        do_cpl(3'b010, 5'b01010, 9, MY_ID, 3'b000, 8, 4, 0, "R13", 1'b1, 9, 20);
        do_alloc(9, 8, "R13");
        good_cpl(10, 40, 16, 0, "R13");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule